// File: doc/BRIEF.md
# Power domain on/off sequencer

This block is a hardware state machine that switches one power-gated domain off and back on. It drives the domain's two-stage power switch, the isolation clamp, the domain clock gate, the domain reset, the retention flop save and restore strobes with their own clock-gating window, and an optional SRAM power-down request. Every step runs in a fixed order. Each acknowledge wait is bounded by a timeout, and the fixed settle delays come from a microsecond time base.

A controller pulses `start_i` for one cycle and uses `dir_up_i` to choose power-up (1) or power-down (0). The block raises `busy_o` for the whole sequence. When the sequence ends it pulses `done_o` for one cycle. A wait that runs out ends the sequence at once, and `err_o` is then set and stays set until the next start. Bus protection is not done here: the block hands it to an external sequencer through a `bp_req_o`/`bp_done_i` handshake. `bp_release_o` tells that sequencer whether to engage protection (0, at the start of power-down) or release it (1, as the last step of power-up). Retention is restored on power-up only when a save has happened since the last restore.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain is taken as off. The block then drives `iso_o`=1, `clk_dis_o`=1, `pwr_rst_n_o`=0, `pwr_on1_o`=0, `pwr_on2_o`=0, `sram_pdn_o`=HAS_SRAM, `ret_restore_n_o`=1, `ret_clk_dis_o`=0, `ret_save_o`=0, `saved_o`=0, `bp_req_o`=0, `busy_o`=0, `done_o`=0 and `err_o`=0.
- R2: Power-down runs in this order. First the bus-protect engage. Then, with SRAM, `sram_pdn_o` rises and the block waits for `sram_ack_i`=1. Then the retention save. Then `iso_o` rises, then `clk_dis_o` rises, then `pwr_rst_n_o` falls. Then `pwr_on1_o` falls and the block waits for `ack1_i`=0. Last, `pwr_on2_o` falls and the block waits for `ack2_i`=0.
- R3: The retention save works like this. `ret_clk_dis_o` rises, `ret_save_o` rises, `ret_save_o` falls, and then `ret_clk_dis_o` falls. At that point `saved_o` becomes 1.
- R4: Power-up runs in this order. `pwr_on1_o` rises and the block waits for `ack1_i`=1. After the settle delay, `pwr_on2_o` rises and the block waits for `ack2_i`=1. Then `clk_dis_o` falls, then `iso_o` falls, and after the reset delay `pwr_rst_n_o` rises.
- R5: The restore step runs only when `saved_o`=1 at the moment reset is released. In that step `ret_clk_dis_o` rises, `ret_restore_n_o` falls, `ret_restore_n_o` rises, and `ret_clk_dis_o` falls. `saved_o` is then cleared. With `saved_o`=0, none of these four outputs changes during power-up.
- R6: On power-up, after the reset release and any restore, `sram_pdn_o` falls (with SRAM) and the block waits for `sram_ack_i`=0. Then the bus-protect release runs as the final step.
- R7: With HAS_SRAM=0, both sequences leave out the SRAM steps, and `sram_pdn_o` stays 0 at all times.
- R8: Suppose an acknowledge wait (bus-protect done, SRAM ack, stage 1 ack or stage 2 ack) does not see its target level within more than TIMEOUT_US microseconds. The sequence then ends with `err_o`=1 and a `done_o` pulse, and no later step changes any control output.
- R9: While `busy_o`=1, `start_i` is ignored. A start with the opposite direction during a sequence changes neither that sequence nor the outputs after it.
- R10: `done_o` is a single-cycle pulse that marks the end of each sequence, in the same cycle that `busy_o` falls. `err_o` stays latched through idle and clears on the next accepted start.
- R11: `bp_req_o` stays high until `bp_done_i` is seen. During power-down `bp_release_o` is 0, and during power-up it is 1.
- R12: The settle delay (SETTLE_US) and the reset delay (RST_US) each last at least their count of microseconds, and never more than two microseconds beyond it. One microsecond is TICK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| dir_up_i | input | 1 | 1 = power up, 0 = power down; sampled with start |
| ack1_i | input | 1 | First power stage acknowledge |
| ack2_i | input | 1 | Second power stage acknowledge |
| sram_ack_i | input | 1 | SRAM power-down acknowledge |
| bp_done_i | input | 1 | Bus-protect sequencer completion |
| bp_req_o | output | 1 | Bus-protect request, held until done |
| bp_release_o | output | 1 | Bus-protect direction: 0 engage, 1 release |
| pwr_on1_o | output | 1 | First power stage enable |
| pwr_on2_o | output | 1 | Second power stage enable |
| iso_o | output | 1 | Output isolation enable |
| clk_dis_o | output | 1 | Domain clock disable |
| pwr_rst_n_o | output | 1 | Domain reset, active low |
| ret_clk_dis_o | output | 1 | Retention clock-gating window |
| ret_save_o | output | 1 | Retention save strobe |
| ret_restore_n_o | output | 1 | Retention restore strobe, active low |
| sram_pdn_o | output | 1 | SRAM power-down request |
| saved_o | output | 1 | Retention holds a valid save |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Latched acknowledge timeout |

## Verification
Some ordering rules can be checked on every cycle, and the embedded assertions cover them. The second stage never switches on before the first stage acknowledges. Isolation lifts only with both stages acknowledged and the clock running. Reset releases only once isolation and the clock gate are off. The first stage is cut only behind isolation, clock gating and reset. Save and restore strobes occur only inside a retention clock window. The bus-protect request is held until completion, and busy always falls together with done. Other behaviours can only be seen across whole scenarios, so the bench shows them. These are the full step order in each direction, the skipped restore when nothing was saved, the delay windows measured in cycles, abandoning a sequence on a stuck acknowledge, a start ignored while busy, and a second instance built without SRAM.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [4:0] {
    S_IDLE,
    S_DN_BP, S_DN_SRAM, S_DN_RCD, S_DN_SAVE_H, S_DN_SAVE_L, S_DN_RCD_OFF,
    S_DN_ISO, S_DN_CLK, S_DN_RST, S_DN_ON1, S_DN_ON2,
    S_UP_ON1, S_UP_SETTLE, S_UP_ON2, S_UP_CLK, S_UP_ISO, S_UP_RST,
    S_UP_RCD, S_UP_RES_L, S_UP_RES_H, S_UP_RCD_OFF, S_UP_SRAM, S_UP_BP
  } pds_state_e;
endpackage

// File: rtl/pds_us_tick.sv
module pds_us_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      always_ff @(posedge clk) tick_o <= !rst;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q  <= '0;
          tick_o <= 1'b0;
        end else if (pre_q == PW'(DIV - 1)) begin
          pre_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          pre_q  <= pre_q + 1'b1;
          tick_o <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pds_us_timer.sv
module pds_us_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (tick_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int SETTLE_US  = 50,
  parameter int RST_US     = 10,
  parameter int TIMEOUT_US = 500,
  parameter bit HAS_SRAM   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic dir_up_i,
  input  logic ack1_i,
  input  logic ack2_i,
  input  logic sram_ack_i,
  input  logic bp_done_i,
  output logic bp_req_o,
  output logic bp_release_o,
  output logic pwr_on1_o,
  output logic pwr_on2_o,
  output logic iso_o,
  output logic clk_dis_o,
  output logic pwr_rst_n_o,
  output logic ret_clk_dis_o,
  output logic ret_save_o,
  output logic ret_restore_n_o,
  output logic sram_pdn_o,
  output logic saved_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int LIM_A = (SETTLE_US > RST_US) ? SETTLE_US : RST_US;
  localparam int LIM   = (TIMEOUT_US > LIM_A) ? TIMEOUT_US : LIM_A;
  localparam int TW    = $clog2(LIM + 2);

  pds_state_e state_q, prev_q, nxt;
  logic          us_tick, entered, ok, is_wait, adv, fail;
  logic [TW-1:0] us_cnt;

  assign entered = (state_q != prev_q);

  pds_us_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(us_tick)
  );

  pds_us_timer #(.CNT_W(TW)) u_tmr (
    .clk(clk), .rst(rst), .clr_i(entered), .tick_i(us_tick), .cnt_o(us_cnt)
  );

  // Step decode: which condition ends each state and where it leads.
  always_comb begin
    ok      = 1'b1;
    is_wait = 1'b0;
    nxt     = S_IDLE;
    case (state_q)
      S_IDLE:       begin ok = start_i; nxt = dir_up_i ? S_UP_ON1 : S_DN_BP; end
      S_DN_BP:      begin is_wait = 1'b1; ok = bp_done_i;
                          nxt = HAS_SRAM ? S_DN_SRAM : S_DN_RCD; end
      S_DN_SRAM:    begin is_wait = 1'b1; ok = sram_ack_i; nxt = S_DN_RCD; end
      S_DN_RCD:     nxt = S_DN_SAVE_H;
      S_DN_SAVE_H:  nxt = S_DN_SAVE_L;
      S_DN_SAVE_L:  nxt = S_DN_RCD_OFF;
      S_DN_RCD_OFF: nxt = S_DN_ISO;
      S_DN_ISO:     nxt = S_DN_CLK;
      S_DN_CLK:     nxt = S_DN_RST;
      S_DN_RST:     nxt = S_DN_ON1;
      S_DN_ON1:     begin is_wait = 1'b1; ok = !ack1_i; nxt = S_DN_ON2; end
      S_DN_ON2:     begin is_wait = 1'b1; ok = !ack2_i; nxt = S_IDLE; end
      S_UP_ON1:     begin is_wait = 1'b1; ok = ack1_i; nxt = S_UP_SETTLE; end
      S_UP_SETTLE:  begin ok = (us_cnt > TW'(SETTLE_US)); nxt = S_UP_ON2; end
      S_UP_ON2:     begin is_wait = 1'b1; ok = ack2_i; nxt = S_UP_CLK; end
      S_UP_CLK:     nxt = S_UP_ISO;
      S_UP_ISO:     begin ok = (us_cnt > TW'(RST_US)); nxt = S_UP_RST; end
      S_UP_RST:     nxt = saved_o ? S_UP_RCD : (HAS_SRAM ? S_UP_SRAM : S_UP_BP);
      S_UP_RCD:     nxt = S_UP_RES_L;
      S_UP_RES_L:   nxt = S_UP_RES_H;
      S_UP_RES_H:   nxt = S_UP_RCD_OFF;
      S_UP_RCD_OFF: nxt = HAS_SRAM ? S_UP_SRAM : S_UP_BP;
      S_UP_SRAM:    begin is_wait = 1'b1; ok = !sram_ack_i; nxt = S_UP_BP; end
      S_UP_BP:      begin is_wait = 1'b1; ok = bp_done_i; nxt = S_IDLE; end
      default:      nxt = S_IDLE;
    endcase
  end

  assign adv  = (state_q == S_IDLE) ? start_i : (ok && !entered);
  assign fail = is_wait && !ok && !entered && (us_cnt > TW'(TIMEOUT_US));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= S_IDLE;
      prev_q          <= S_IDLE;
      bp_req_o        <= 1'b0;
      bp_release_o    <= 1'b0;
      pwr_on1_o       <= 1'b0;
      pwr_on2_o       <= 1'b0;
      iso_o           <= 1'b1;
      clk_dis_o       <= 1'b1;
      pwr_rst_n_o     <= 1'b0;
      ret_clk_dis_o   <= 1'b0;
      ret_save_o      <= 1'b0;
      ret_restore_n_o <= 1'b1;
      sram_pdn_o      <= HAS_SRAM;
      saved_o         <= 1'b0;
      busy_o          <= 1'b0;
      done_o          <= 1'b0;
      err_o           <= 1'b0;
    end else begin
      prev_q <= state_q;
      done_o <= 1'b0;
      if (fail) begin
        state_q <= S_IDLE;
        busy_o  <= 1'b0;
        done_o  <= 1'b1;
        err_o   <= 1'b1;
      end else if (adv) begin
        state_q <= nxt;
        if (state_q == S_IDLE) begin
          err_o  <= 1'b0;
          busy_o <= 1'b1;
        end else if (nxt == S_IDLE) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
      case (state_q)
        S_DN_BP:      begin bp_req_o <= !adv && !fail; bp_release_o <= 1'b0; end
        S_DN_SRAM:    sram_pdn_o      <= 1'b1;
        S_DN_RCD:     ret_clk_dis_o   <= 1'b1;
        S_DN_SAVE_H:  ret_save_o      <= 1'b1;
        S_DN_SAVE_L:  ret_save_o      <= 1'b0;
        S_DN_RCD_OFF: begin ret_clk_dis_o <= 1'b0; saved_o <= 1'b1; end
        S_DN_ISO:     iso_o           <= 1'b1;
        S_DN_CLK:     clk_dis_o       <= 1'b1;
        S_DN_RST:     pwr_rst_n_o     <= 1'b0;
        S_DN_ON1:     pwr_on1_o       <= 1'b0;
        S_DN_ON2:     pwr_on2_o       <= 1'b0;
        S_UP_ON1:     pwr_on1_o       <= 1'b1;
        S_UP_ON2:     pwr_on2_o       <= 1'b1;
        S_UP_CLK:     clk_dis_o       <= 1'b0;
        S_UP_ISO:     iso_o           <= 1'b0;
        S_UP_RST:     pwr_rst_n_o     <= 1'b1;
        S_UP_RCD:     ret_clk_dis_o   <= 1'b1;
        S_UP_RES_L:   ret_restore_n_o <= 1'b0;
        S_UP_RES_H:   ret_restore_n_o <= 1'b1;
        S_UP_RCD_OFF: begin ret_clk_dis_o <= 1'b0; saved_o <= 1'b0; end
        S_UP_SRAM:    sram_pdn_o      <= 1'b0;
        S_UP_BP:      begin bp_req_o <= !adv && !fail; bp_release_o <= 1'b1; end
        default:      ;
      endcase
    end
  end

  // R4
  on2_after_ack1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_on2_o) |-> (pwr_on1_o && ack1_i))
    else $error("second stage enabled before first stage acknowledged");

  // R4
  iso_lift_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_o) |-> (pwr_on2_o && ack2_i && !clk_dis_o))
    else $error("isolation lifted on an unpowered or gated domain");

  // R4
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_rst_n_o) |-> (!iso_o && !clk_dis_o))
    else $error("reset released while isolated or gated");

  // R2
  power_cut_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_on1_o) |-> (iso_o && clk_dis_o && !pwr_rst_n_o))
    else $error("first stage cut without isolation, gating and reset");

  // R3
  save_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ret_save_o) |-> ret_clk_dis_o)
    else $error("save strobe outside retention clock window");

  // R5
  restore_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ret_restore_n_o) |-> (ret_clk_dis_o && saved_o))
    else $error("restore strobe without window or without a save");

  // R11
  bp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_req_o && !bp_done_i) |=> (bp_req_o || err_o))
    else $error("bus-protect request dropped before completion");

  // R10
  done_with_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o)
    else $error("busy fell without a done pulse");

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");
endmodule

// File: tb/pwr_domain_seq_tb.sv
module pwr_domain_seq_tb;
  localparam int DIV = 4;
  localparam int SET = 50;
  localparam int RDL = 10;
  localparam int TMO = 500;

  localparam int E_BPREQ = 0,  E_SRAM_R = 1, E_SRAM_F = 2, E_RCD_R = 3, E_RCD_F = 4;
  localparam int E_SAVE_R = 5, E_SAVE_F = 6, E_RES_F = 7,  E_RES_R = 8, E_ISO_R = 9;
  localparam int E_ISO_F = 10, E_CLK_R = 11, E_CLK_F = 12, E_RST_R = 13, E_RST_F = 14;
  localparam int E_ON1_R = 15, E_ON1_F = 16, E_ON2_R = 17, E_ON2_F = 18, E_ACK1_R = 19;
  localparam int E_DONE = 20,  NEV = 21;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, dir = 1'b0, hold1 = 1'b0;
  logic ack1, ack2, sack, bp_done;
  logic bp_req, bp_rel, on1, on2, iso, cdis, rstn, rcd, save, resn, spdn, saved, busy, done, err;

  logic ns_start = 1'b0, ns_dir = 1'b0;
  logic ns_ack1, ns_ack2, ns_bp_done;
  logic ns_bp_req, ns_bp_rel, ns_on1, ns_on2, ns_iso, ns_cdis, ns_rstn, ns_rcd, ns_save;
  logic ns_resn, ns_spdn, ns_saved, ns_busy, ns_done, ns_err;

  int checks = 0, errors = 0, cyc = 0;
  int ev[NEV];
  int done_cnt = 0, ns_done_cnt = 0, bprel_at = -1;
  bit ns_sram_seen = 1'b0;
  logic p_bp, p_sp, p_rcd, p_sv, p_rs, p_iso, p_cd, p_rn, p_o1, p_o2, p_a1;

  always #5 clk = ~clk;

  pwr_domain_seq #(.TICK_DIV(DIV), .SETTLE_US(SET), .RST_US(RDL), .TIMEOUT_US(TMO),
                   .HAS_SRAM(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .dir_up_i(dir), .ack1_i(ack1), .ack2_i(ack2),
    .sram_ack_i(sack), .bp_done_i(bp_done), .bp_req_o(bp_req), .bp_release_o(bp_rel),
    .pwr_on1_o(on1), .pwr_on2_o(on2), .iso_o(iso), .clk_dis_o(cdis), .pwr_rst_n_o(rstn),
    .ret_clk_dis_o(rcd), .ret_save_o(save), .ret_restore_n_o(resn), .sram_pdn_o(spdn),
    .saved_o(saved), .busy_o(busy), .done_o(done), .err_o(err));

  pwr_domain_seq #(.TICK_DIV(DIV), .SETTLE_US(SET), .RST_US(RDL), .TIMEOUT_US(TMO),
                   .HAS_SRAM(1'b0)) u_dut_ns (
    .clk(clk), .rst(rst), .start_i(ns_start), .dir_up_i(ns_dir), .ack1_i(ns_ack1),
    .ack2_i(ns_ack2), .sram_ack_i(1'b0), .bp_done_i(ns_bp_done), .bp_req_o(ns_bp_req),
    .bp_release_o(ns_bp_rel), .pwr_on1_o(ns_on1), .pwr_on2_o(ns_on2), .iso_o(ns_iso),
    .clk_dis_o(ns_cdis), .pwr_rst_n_o(ns_rstn), .ret_clk_dis_o(ns_rcd), .ret_save_o(ns_save),
    .ret_restore_n_o(ns_resn), .sram_pdn_o(ns_spdn), .saved_o(ns_saved), .busy_o(ns_busy),
    .done_o(ns_done), .err_o(ns_err));

  // Environment: acknowledges follow their requests one cycle later.
  always_ff @(posedge clk) begin
    if (rst) begin
      ack1 <= 1'b0; ack2 <= 1'b0; sack <= 1'b0; bp_done <= 1'b0;
      ns_ack1 <= 1'b0; ns_ack2 <= 1'b0; ns_bp_done <= 1'b0;
    end else begin
      ack1 <= hold1 ? ack1 : on1;
      ack2 <= on2;
      sack <= spdn;
      bp_done <= bp_req && !bp_done;
      ns_ack1 <= ns_on1;
      ns_ack2 <= ns_on2;
      ns_bp_done <= ns_bp_req && !ns_bp_done;
    end
  end

  // Edge monitor, sampled away from the active edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (bp_req && !p_bp) begin ev[E_BPREQ] = cyc; bprel_at = int'(bp_rel); end
      if (spdn && !p_sp)  ev[E_SRAM_R] = cyc;
      if (!spdn && p_sp)  ev[E_SRAM_F] = cyc;
      if (rcd && !p_rcd)  ev[E_RCD_R] = cyc;
      if (!rcd && p_rcd)  ev[E_RCD_F] = cyc;
      if (save && !p_sv)  ev[E_SAVE_R] = cyc;
      if (!save && p_sv)  ev[E_SAVE_F] = cyc;
      if (!resn && p_rs)  ev[E_RES_F] = cyc;
      if (resn && !p_rs)  ev[E_RES_R] = cyc;
      if (iso && !p_iso)  ev[E_ISO_R] = cyc;
      if (!iso && p_iso)  ev[E_ISO_F] = cyc;
      if (cdis && !p_cd)  ev[E_CLK_R] = cyc;
      if (!cdis && p_cd)  ev[E_CLK_F] = cyc;
      if (rstn && !p_rn)  ev[E_RST_R] = cyc;
      if (!rstn && p_rn)  ev[E_RST_F] = cyc;
      if (on1 && !p_o1)   ev[E_ON1_R] = cyc;
      if (!on1 && p_o1)   ev[E_ON1_F] = cyc;
      if (on2 && !p_o2)   ev[E_ON2_R] = cyc;
      if (!on2 && p_o2)   ev[E_ON2_F] = cyc;
      if (ack1 && !p_a1)  ev[E_ACK1_R] = cyc;
      if (done) begin ev[E_DONE] = cyc; done_cnt = done_cnt + 1; end
      if (ns_done) ns_done_cnt = ns_done_cnt + 1;
      if (ns_spdn) ns_sram_seen = 1'b1;
    end
    p_bp = bp_req; p_sp = spdn; p_rcd = rcd; p_sv = save; p_rs = resn; p_iso = iso;
    p_cd = cdis; p_rn = rstn; p_o1 = on1; p_o2 = on2; p_a1 = ack1;
  end

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!good) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ord(input string req, input string what, input int a, input int b);
    chk(a >= 0 && b > a, req, what, b, a + 1);
  endtask

  task automatic clear_ev();
    for (int i = 0; i < NEV; i++) ev[i] = -1;
    done_cnt = 0;
    bprel_at = -1;
  endtask

  task automatic kick(input logic up);
    @(negedge clk); start = 1'b1; dir = up;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    // R1
    chk(iso && cdis && !rstn, "R1", "iso/clkdis/rst_n", {iso, cdis, rstn}, 3'b110);
    chk(!on1 && !on2, "R1", "power stages", {on1, on2}, 0);
    chk(spdn && resn && !rcd && !save && !saved, "R1", "sram/retention",
        {spdn, resn, rcd, save, saved}, 5'b11000);
    chk(!bp_req && !busy && !done && !err, "R1", "handshake/status",
        {bp_req, busy, done, err}, 0);
    chk(!ns_spdn, "R7", "no-SRAM reset pdn", ns_spdn, 0);
  endtask

  task automatic t_up_cold();
    clear_ev();
    kick(1'b1);
    @(negedge clk);
    chk(busy, "R10", "busy during sequence", busy, 1);
    wait_done();
    // R4
    ord("R4", "on1 before ack1", ev[E_ON1_R], ev[E_ACK1_R]);
    ord("R4", "ack1 before on2", ev[E_ACK1_R], ev[E_ON2_R]);
    ord("R4", "on2 before clk enable", ev[E_ON2_R], ev[E_CLK_F]);
    ord("R4", "clk enable before iso off", ev[E_CLK_F], ev[E_ISO_F]);
    ord("R4", "iso off before reset release", ev[E_ISO_F], ev[E_RST_R]);
    // R12
    chk(ev[E_ON2_R] - ev[E_ACK1_R] >= SET * DIV && ev[E_ON2_R] - ev[E_ACK1_R] <= (SET + 2) * DIV + 6,
        "R12", "settle cycles", ev[E_ON2_R] - ev[E_ACK1_R], SET * DIV);
    chk(ev[E_RST_R] - ev[E_ISO_F] >= RDL * DIV && ev[E_RST_R] - ev[E_ISO_F] <= (RDL + 2) * DIV + 6,
        "R12", "reset delay cycles", ev[E_RST_R] - ev[E_ISO_F], RDL * DIV);
    // R5: nothing saved, so no restore activity
    chk(ev[E_RES_F] == -1 && ev[E_RCD_R] == -1, "R5", "no restore without save",
        ev[E_RES_F], -1);
    // R6
    ord("R6", "reset release before sram on", ev[E_RST_R], ev[E_SRAM_F]);
    ord("R6", "sram on before bp release", ev[E_SRAM_F], ev[E_BPREQ]);
    ord("R6", "bp release before done", ev[E_BPREQ], ev[E_DONE]);
    // R11
    chk(bprel_at == 1, "R11", "bp direction on power-up", bprel_at, 1);
    // R10
    chk(done_cnt == 1 && !busy && !err, "R10", "single done pulse", done_cnt, 1);
  endtask

  task automatic t_down_busy_ignore();
    clear_ev();
    kick(1'b0);
    repeat (4) @(negedge clk);
    start = 1'b1; dir = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    // R2
    ord("R2", "bp engage before sram off", ev[E_BPREQ], ev[E_SRAM_R]);
    ord("R2", "sram off before save", ev[E_SRAM_R], ev[E_RCD_R]);
    ord("R2", "save window before iso", ev[E_RCD_F], ev[E_ISO_R]);
    ord("R2", "iso before clk disable", ev[E_ISO_R], ev[E_CLK_R]);
    ord("R2", "clk disable before reset", ev[E_CLK_R], ev[E_RST_F]);
    ord("R2", "reset before stage1 off", ev[E_RST_F], ev[E_ON1_F]);
    ord("R2", "stage1 off before stage2 off", ev[E_ON1_F], ev[E_ON2_F]);
    // R3
    ord("R3", "window open before save", ev[E_RCD_R], ev[E_SAVE_R]);
    ord("R3", "save high before low", ev[E_SAVE_R], ev[E_SAVE_F]);
    ord("R3", "save low before window close", ev[E_SAVE_F], ev[E_RCD_F]);
    chk(saved, "R3", "saved flag set", saved, 1);
    // R11
    chk(bprel_at == 0, "R11", "bp direction on power-down", bprel_at, 0);
    // R9
    chk(done_cnt == 1 && !on1 && !on2, "R9", "mid-sequence start ignored",
        {done_cnt[1:0], on1, on2}, 4'b0100);
    repeat (30) @(negedge clk);
    chk(!busy && !on1 && ev[E_ON1_R] == -1, "R9", "no restart after ignored start",
        {busy, on1}, 0);
  endtask

  task automatic t_up_restore();
    clear_ev();
    kick(1'b1);
    wait_done();
    // R5
    ord("R5", "reset release before window", ev[E_RST_R], ev[E_RCD_R]);
    ord("R5", "window before restore low", ev[E_RCD_R], ev[E_RES_F]);
    ord("R5", "restore low before high", ev[E_RES_F], ev[E_RES_R]);
    ord("R5", "restore high before window close", ev[E_RES_R], ev[E_RCD_F]);
    chk(!saved, "R5", "saved flag cleared", saved, 0);
    // R6
    ord("R6", "restore before sram on", ev[E_RCD_F], ev[E_SRAM_F]);
    chk(!err && on1 && on2 && rstn && !iso, "R4", "domain fully on",
        {err, on1, on2, rstn, iso}, 5'b01110);
  endtask

  task automatic t_timeout();
    clear_ev();
    hold1 = 1'b1;
    kick(1'b0);
    wait_done();
    // R8
    chk(err && done_cnt == 1 && !busy, "R8", "abort with error", {err, busy}, 2'b10);
    chk(on2 && ev[E_ON2_F] == -1, "R8", "stage2 left untouched", on2, 1);
    chk(ev[E_DONE] - ev[E_ON1_F] >= TMO * DIV && ev[E_DONE] - ev[E_ON1_F] <= (TMO + 2) * DIV + 6,
        "R8", "timeout cycles", ev[E_DONE] - ev[E_ON1_F], TMO * DIV);
    repeat (40) @(negedge clk);
    // R10
    chk(err && on2, "R10", "error stays latched", err, 1);
    hold1 = 1'b0;
    repeat (4) @(negedge clk);
    clear_ev();
    kick(1'b1);
    @(negedge clk);
    chk(!err && busy, "R10", "error cleared by start", err, 0);
    wait_done();
    chk(!err && done_cnt == 1 && rstn, "R10", "recovery sequence clean", err, 0);
  endtask

  task automatic t_no_sram();
    @(negedge clk); ns_start = 1'b1; ns_dir = 1'b1;
    @(negedge clk); ns_start = 1'b0;
    for (int i = 0; i < 20000 && ns_done_cnt == 0; i++) @(negedge clk);
    // R7
    chk(ns_done_cnt == 1 && !ns_err && ns_rstn, "R7", "no-SRAM power-up", ns_done_cnt, 1);
    ns_done_cnt = 0;
    @(negedge clk); ns_start = 1'b1; ns_dir = 1'b0;
    @(negedge clk); ns_start = 1'b0;
    for (int i = 0; i < 20000 && ns_done_cnt == 0; i++) @(negedge clk);
    chk(ns_done_cnt == 1 && !ns_err && !ns_on2 && ns_saved, "R7", "no-SRAM power-down",
        ns_done_cnt, 1);
    chk(!ns_sram_seen, "R7", "sram request never raised", ns_sram_seen, 0);
  endtask

  initial begin
    clear_ev();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_up_cold();
    t_down_busy_ignore();
    t_up_restore();
    t_timeout();
    t_no_sram();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule